// File: doc/BRIEF.md
# Conversion Scheduler with One-Shot

This block decides when a temperature converter begins a conversion. It has two modes. In autonomous mode a programmable interval timer starts conversions again and again. In standby mode the block waits and starts a conversion only when asked. A one-shot write can force an immediate conversion in either mode.

The scheduler sends a single-cycle start pulse to the converter and waits for the converter's done signal. While a conversion runs it raises a busy flag that the status register can show.

The interval is counted in pulses of a slow tick input, not in system clocks. The rate code picks the interval as a base tick count shifted right by the code. With the default base of 128 ticks and a tick of one eighth of a second, code 0 gives 16 s and code 7 gives 1/8 s.

The controller has three named states:
- STANDBY: no timer runs. It leaves when a one-shot arrives, or when the mode input selects autonomous.
- WAITING: the interval timer counts ticks. It leaves on a one-shot, on a change to standby, or when the interval expires.
- CONVERTING: it waits for the done signal. It then goes to STANDBY or WAITING, depending on the mode input at that moment.

Top module: `conv_sched`

## Requirements
- R1: After reset, `conv_start` and `busy` are 0 and the block is in STANDBY.
- R2: While `standby` is 1, no conversion starts except by a one-shot, whatever the tick and rate inputs do.
- R3: `conv_start` is high for exactly one cycle. That cycle is the first cycle in which `busy` is high. `busy` stays high until `conv_done` is sampled, and it is low from the next cycle on.
- R4: A one-shot in STANDBY makes `conv_start` high in the cycle after the strobe is sampled. After that conversion completes, the block is back in STANDBY and starts nothing more on its own.
- R5: A one-shot sampled while `busy` is 1 is ignored. It makes no start pulse, and the next autonomous conversion still waits a full interval after the conversion in progress ends.
- R6: A one-shot in WAITING starts a conversion in the next cycle and discards the partly counted interval. The next automatic start comes a full interval after that conversion ends.
- R7: The interval is L = BASE_TICKS >> code ticks, counted from the edge that samples `conv_done`. The conversion starts on the edge that samples the L-th tick after that one.
- R8: Rate codes above 7 behave exactly like code 7, giving L = 1 with the default base.
- R9: Only cycles with `tick` = 1 advance the interval. With one tick every P cycles, the start comes P·L cycles after the done edge.
- R10: When `standby` falls to 0 in STANDBY, a conversion starts in the next cycle.
- R11: If `standby` rises during a conversion, the conversion still runs until `conv_done`. After that, no automatic conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Interval time base, one-cycle pulses |
| standby | input | 1 | Mode bit: 1 = standby, 0 = autonomous |
| rate_code | input | 8 | Conversion rate code; values above 7 saturate |
| oneshot_wr | input | 1 | One-cycle strobe for a one-shot command write |
| conv_done | input | 1 | Converter reports the end of a conversion |
| conv_start | output | 1 | One-cycle pulse that starts a conversion |
| busy | output | 1 | High while a conversion is in progress |

## Verification
The assertions assume that the converter raises `conv_done` only while `busy` is high. They also assume that `oneshot_wr` and `tick` are single-cycle strobes taken at clock edges. The bench keeps to these assumptions: it pulses `conv_done` only after it has seen `busy`, and it drives every strobe for exactly one cycle at the falling edge.

The rate sweep covers all eight codes and several codes that saturate, with a tick every cycle. The run then repeats with a sparse tick. The one-shot checks are placed inside a conversion, inside a partly counted interval, and in standby.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

    typedef enum logic [1:0] {
        S_STANDBY    = 2'd0,
        S_WAITING    = 2'd1,
        S_CONVERTING = 2'd2
    } sched_state_e;

endpackage

// File: rtl/conv_rate_decode.sv
module conv_rate_decode #(
    parameter int RATE_W     = 8,
    parameter int BASE_TICKS = 128,
    parameter int MAX_CODE   = 7,
    parameter int CNT_W      = $clog2(BASE_TICKS + 1)
) (
    input  logic [RATE_W-1:0] rate_code,
    output logic [CNT_W-1:0]  limit
);
    localparam int CODE_W = $clog2(MAX_CODE + 1);

    logic [CODE_W-1:0] code_sat;
    logic [CNT_W-1:0]  limit_tab [MAX_CODE+1];

    // Interval for each legal code, computed from the base
    for (genvar g = 0; g <= MAX_CODE; g++) begin : g_tab
        assign limit_tab[g] = CNT_W'(BASE_TICKS >> g);
    end

    always_comb begin
        if (rate_code > RATE_W'(MAX_CODE)) begin
            code_sat = CODE_W'(MAX_CODE);
        end else begin
            code_sat = rate_code[CODE_W-1:0];
        end
        limit = limit_tab[code_sat];
    end

endmodule

// File: rtl/conv_interval_timer.sv
module conv_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    // A shrinking limit during a wait still expires on the next tick
    assign expire = run && tick && (cnt >= limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R7: the count restarts from zero whenever waiting is left
    a_r7_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    // R9: a cycle without a tick leaves the count unchanged while waiting
    a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && $past(run) && $past(rst_n)) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/conv_sched_fsm.sv
module conv_sched_fsm
    import conv_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic oneshot_wr,
    input  logic conv_done,
    input  logic expire,
    output logic run,
    output logic conv_start,
    output logic busy
);
    sched_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_STANDBY: begin
                if (oneshot_wr || !standby) state_nx = S_CONVERTING;
            end
            S_WAITING: begin
                if (oneshot_wr)   state_nx = S_CONVERTING;
                else if (standby) state_nx = S_STANDBY;
                else if (expire)  state_nx = S_CONVERTING;
            end
            S_CONVERTING: begin
                if (conv_done) state_nx = standby ? S_STANDBY : S_WAITING;
            end
            default: state_nx = S_STANDBY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_STANDBY;
        else        state <= state_nx;
    end

    // Registered outputs, aligned with the state they describe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            busy       <= 1'b0;
        end else begin
            conv_start <= (state_nx == S_CONVERTING) && (state != S_CONVERTING);
            busy       <= (state_nx == S_CONVERTING);
        end
    end

    assign run = (state == S_WAITING);

    // R3: the start pulse lasts one cycle
    a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R3: the start pulse coincides with busy
    a_r3_start_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    // R3: busy holds until done is seen
    a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> busy);

    // R5: a one-shot during a conversion produces no start
    a_r5_oneshot_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && oneshot_wr) |=> !conv_start);

    // R2: in standby without a one-shot nothing starts
    a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_CONVERTING && standby && !oneshot_wr) |=> !conv_start);

    // R4: a one-shot outside a conversion starts one
    a_r4_oneshot_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && oneshot_wr) |=> conv_start);

endmodule

// File: rtl/conv_sched.sv
module conv_sched #(
    parameter int RATE_W     = 8,
    parameter int BASE_TICKS = 128,
    parameter int MAX_CODE   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              standby,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              oneshot_wr,
    input  logic              conv_done,
    output logic              conv_start,
    output logic              busy
);
    localparam int CNT_W = $clog2(BASE_TICKS + 1);

    logic [CNT_W-1:0] limit;
    logic             run;
    logic             expire;

    conv_rate_decode #(
        .RATE_W    (RATE_W),
        .BASE_TICKS(BASE_TICKS),
        .MAX_CODE  (MAX_CODE),
        .CNT_W     (CNT_W)
    ) u_decode (
        .rate_code(rate_code),
        .limit    (limit)
    );

    conv_interval_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .limit (limit),
        .expire(expire)
    );

    conv_sched_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .oneshot_wr(oneshot_wr),
        .conv_done (conv_done),
        .expire    (expire),
        .run       (run),
        .conv_start(conv_start),
        .busy      (busy)
    );

endmodule

// File: tb/sim_conv_sched.sv
module sim_conv_sched;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 128;
    localparam int WDOG_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic       standby;
    logic [7:0] rate_code;
    logic       oneshot_wr;
    logic       conv_done;
    logic       conv_start;
    logic       busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_sched u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .standby(standby),
        .rate_code(rate_code), .oneshot_wr(oneshot_wr), .conv_done(conv_done),
        .conv_start(conv_start), .busy(busy)
    );

    function automatic int exp_len(input int code);
        int c;
        c = (code > 7) ? 7 : code;
        return BASE >> c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Pulse done; count ticks and cycles until the next start pulse
    task automatic measure(input int period, output int nticks, output int ncyc);
        nticks = 0;
        ncyc   = 0;
        conv_done = 1'b1;
        tick      = 1'b0;
        step();
        conv_done = 1'b0;
        check(busy == 1'b0, "R3 busy drop", int'(busy), 0);
        for (int k = 1; k < 4000; k++) begin
            tick = ((k % period) == 0);
            @(posedge clk);
            if (tick) nticks++;
            @(negedge clk);
            ncyc++;
            if (conv_start) break;
        end
        tick = 1'b0;
    endtask

    task automatic quiet(input int n, input string req);
        int starts;
        starts = 0;
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            step();
            if (conv_start) starts++;
        end
        tick = 1'b0;
        check(starts == 0, req, starts, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG_LIMIT && !finished) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int nt, nc;
        rst_n = 1'b0; tick = 1'b0; standby = 1'b1; rate_code = 8'd3;
        oneshot_wr = 1'b0; conv_done = 1'b0;
        @(negedge clk);
        step(); step();
        rst_n = 1'b1;
        step();
        // R1
        check(conv_start == 1'b0, "R1 start", int'(conv_start), 0);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);

        // R2: standby ignores ticks and the rate code
        rate_code = 8'd7;
        quiet(60, "R2 standby");

        // R4: one-shot in standby
        oneshot_wr = 1'b1;
        step();
        oneshot_wr = 1'b0;
        check(conv_start == 1'b1, "R4 start", int'(conv_start), 1);
        check(busy == 1'b1, "R3 busy", int'(busy), 1);
        step();
        check(conv_start == 1'b0, "R3 single", int'(conv_start), 0);
        // R5: one-shot while busy
        oneshot_wr = 1'b1;
        step();
        oneshot_wr = 1'b0;
        check(conv_start == 1'b0, "R5 ignored", int'(conv_start), 0);
        check(busy == 1'b1, "R3 hold", int'(busy), 1);
        conv_done = 1'b1;
        step();
        conv_done = 1'b0;
        check(busy == 1'b0, "R4 done", int'(busy), 0);
        quiet(40, "R4 back to standby");

        // R10: enter autonomous
        rate_code = 8'd0;
        standby = 1'b0;
        step();
        check(conv_start == 1'b1, "R10 entry", int'(conv_start), 1);
        step();

        // R7 and R8: sweep the codes
        for (int c = 0; c < 12; c++) begin
            int code;
            code = (c < 8) ? c : ((c == 8) ? 8 : ((c == 9) ? 9 : ((c == 10) ? 200 : 255)));
            rate_code = 8'(code);
            measure(1, nt, nc);
            if (code > 7) check(nc == exp_len(code), "R8 saturate", nc, exp_len(code));
            else          check(nc == exp_len(code), "R7 interval", nc, exp_len(code));
        end

        // R9: sparse tick
        rate_code = 8'd5;
        measure(3, nt, nc);
        check(nt == 4, "R9 ticks", nt, 4);
        check(nc == 12, "R9 cycles", nc, 12);

        // R6: one-shot between conversions
        rate_code = 8'd3;
        conv_done = 1'b1;
        step();
        conv_done = 1'b0;
        for (int k = 0; k < 6; k++) begin
            tick = 1'b1;
            step();
        end
        tick = 1'b0;
        check(conv_start == 1'b0, "R6 not yet", int'(conv_start), 0);
        oneshot_wr = 1'b1;
        step();
        oneshot_wr = 1'b0;
        check(conv_start == 1'b1, "R6 start", int'(conv_start), 1);
        measure(1, nt, nc);
        check(nc == 16, "R6 full interval", nc, 16);

        // R5: one-shot during an autonomous conversion
        step();
        oneshot_wr = 1'b1;
        step();
        oneshot_wr = 1'b0;
        check(conv_start == 1'b0, "R5 auto ignored", int'(conv_start), 0);
        measure(1, nt, nc);
        check(nc == 16, "R5 interval intact", nc, 16);

        // R11: standby raised during a conversion
        standby = 1'b1;
        for (int k = 0; k < 5; k++) step();
        check(busy == 1'b1, "R11 finish", int'(busy), 1);
        conv_done = 1'b1;
        step();
        conv_done = 1'b0;
        check(busy == 1'b0, "R11 done", int'(busy), 0);
        quiet(300, "R11 stopped");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule